// File: doc/BRIEF.md
# Line Interface System-Side Mode Controller

This block sits between the system side and the line-side logic of one channel of a T1/E1 line interface. It chooses one of three system data formats: dual rail with clock recovery (the default), single rail with clock recovery, or dual rail with raw sliced data and no clock recovery. It then routes the transmit and receive signals to match that format. Single rail can be entered in two ways. One is automatic: the transmit negative-rail pin is held high for a sustained time. The other is two configuration inputs. In that second case the negative-rail pin is reused as a bipolar-violation insert request.

On the receive side the block selects between the decoder outputs (data and code violation) and the recovered rails. A single edge-select input does one of two jobs. In the clock-recovery formats it inverts the output clock, so data changes on its rising or its falling edge. In raw format it sets the polarity of the rails. In raw format the receive clock is the XOR of the two raw rails. A power-down input drops the output enables of the receive data and clock pins. Those enables model high impedance at the chip pads.

All outputs are registered. The mode is registered in one stage. The data outputs are registered one clock later, from the inputs of that cycle and the mode already held.

Top module: `lif_sysmode`

## Requirements
- R1: While `rst` is high, at every clock edge `mode` becomes 0 and every other output becomes 0.
- R2: `mode` encodes the format as follows: 0 is dual rail with clock recovery, 1 is single rail selected by the pin, 2 is single rail selected by configuration, and 3 is dual rail raw. If `tx_n` is sampled high at 17 consecutive clock edges, `mode` becomes 1 at the 17th edge. Sixteen such edges are not enough.
- R3: A clock edge that samples `tx_n` low clears the run of high samples. If `mode` is 1, that same edge also takes it out of mode 1.
- R4: When `cfg_cr_sel` and `cfg_sr_sel` are both high, `mode` becomes 2 at the next edge. This overrides both the pin-selected single rail and raw format.
- R5: When neither single-rail condition holds, `cfg_raw` high gives `mode` 3 and `cfg_raw` low gives `mode` 0, both at the next edge.
- R6: One edge after a given held mode, the transmit outputs follow it. In modes 0 and 3, `tx_p_out`=`tx_p`, `tx_n_out`=`tx_n` and `tx_single`=0. In modes 1 and 2, `tx_p_out`=`tx_p`, `tx_n_out`=0 and `tx_single`=1.
- R7: `tx_bpv` goes high only in mode 2, and only when `cfg_ami` is high, and then it copies `tx_n`. In every other case it is 0.
- R8: In modes 1 and 2, `rd_p` copies `dec_data`, `rd_n` copies `dec_cv`, and `rd_clk` equals `rec_clk` XOR `clke`.
- R9: In mode 0, `rd_p` copies `rx_p`, `rd_n` copies `rx_n`, and `rd_clk` equals `rec_clk` XOR `clke`. With `clke` high the output clock is inverted, so data changes on its falling edge.
- R10: In mode 3, `rd_clk` equals `rx_p` XOR `rx_n`. With `clke` low the rails are inverted (active low): `rd_p`=NOT `rx_p` and `rd_n`=NOT `rx_n`. With `clke` high they pass through unchanged (active high).
- R11: `rd_oe` and `rclk_oe` each become the inverse of `pwr_down` one edge after `pwr_down` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_raw | input | 1 | Selects raw dual-rail format when single rail is not active |
| cfg_cr_sel | input | 1 | Configuration bit 1 of 2 for single rail |
| cfg_sr_sel | input | 1 | Configuration bit 2 of 2 for single rail |
| cfg_ami | input | 1 | AMI line code selected |
| clke | input | 1 | Edge select in clock-recovery formats; rail polarity in raw format |
| pwr_down | input | 1 | Receiver powered down |
| tx_p | input | 1 | Transmit data or positive rail from the system |
| tx_n | input | 1 | Transmit negative rail, single-rail strap, or violation insert request |
| rec_clk | input | 1 | Recovered clock level |
| rx_p | input | 1 | Receive positive rail |
| rx_n | input | 1 | Receive negative rail |
| dec_data | input | 1 | Decoded receive data |
| dec_cv | input | 1 | Decoder code-violation flag |
| mode | output | 2 | Current format code |
| tx_p_out | output | 1 | Transmit data or positive rail to the line side |
| tx_n_out | output | 1 | Transmit negative rail to the line side |
| tx_bpv | output | 1 | Violation insert request to the encoder |
| tx_single | output | 1 | Encoder enable (single rail active) |
| rd_p | output | 1 | Receive data or positive rail to the system |
| rd_n | output | 1 | Code violation or negative rail to the system |
| rd_clk | output | 1 | Receive clock to the system |
| rd_oe | output | 1 | Output enable for `rd_p` and `rd_n` |
| rclk_oe | output | 1 | Output enable for `rd_clk` |

## Verification
A wrong count of consecutive high samples appears directly on `mode`. A detection one edge early or one edge late moves the step to 1 away from the 17th edge, and a missed clear leaves the run too short after a single low sample. A wrong mode held in the register shows up one edge later on every data output together. For example, `tx_n_out` is not forced to 0, `rd_clk` switches between the rail XOR and the recovered clock, or `tx_bpv` fires outside mode 2. A polarity or edge-select error shows as an inverted `rd_p`, `rd_n` or `rd_clk` in the cycle after the inputs are applied.

// File: rtl/lif_sysmode_pkg.sv
package lif_sysmode_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL   = 2'd0,
    MODE_SR_PIN = 2'd1,
    MODE_SR_CFG = 2'd2,
    MODE_RAW    = 2'd3
  } sysif_mode_e;
endpackage

// File: rtl/lif_mode_detect.sv
module lif_mode_detect
  import lif_sysmode_pkg::*;
#(
  parameter int HIGH_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_n,
  input  logic        cfg_raw,
  input  logic        cfg_cr_sel,
  input  logic        cfg_sr_sel,
  output sysif_mode_e mode_q
);
  localparam int CNT_W = $clog2(HIGH_LIMIT + 2);
  localparam logic [CNT_W-1:0] TH_V  = CNT_W'(HIGH_LIMIT);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(HIGH_LIMIT + 1);

  logic [CNT_W-1:0] run_q;
  sysif_mode_e      mode_d;
  logic             cfg_single;
  logic             pin_single;

  assign cfg_single = cfg_cr_sel && cfg_sr_sel;
  assign pin_single = tx_n && (run_q >= TH_V);

  always_comb begin
    if (cfg_single)      mode_d = MODE_SR_CFG;
    else if (pin_single) mode_d = MODE_SR_PIN;
    else if (cfg_raw)    mode_d = MODE_RAW;
    else                 mode_d = MODE_DUAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      mode_q <= MODE_DUAL;
    end else begin
      if (!tx_n)               run_q <= '0;
      else if (run_q != SAT_V) run_q <= run_q + 1'b1;
      mode_q <= mode_d;
    end
  end

  // R2: pin-selected single rail needs tx_n high at the edge that set it
  a_r2_pin_needs_high: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SR_PIN) |-> $past(tx_n));

  // R3: a low sample always leaves pin-selected single rail
  a_r3_low_leaves: assert property (@(posedge clk) disable iff (rst)
    (!tx_n) |=> (mode_q != MODE_SR_PIN));

  // R4: configuration pair wins over everything
  a_r4_cfg_priority: assert property (@(posedge clk) disable iff (rst)
    (cfg_cr_sel && cfg_sr_sel) |=> (mode_q == MODE_SR_CFG));
endmodule

// File: rtl/lif_tx_path.sv
module lif_tx_path
  import lif_sysmode_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  sysif_mode_e mode,
  input  logic        cfg_ami,
  input  logic        tx_p,
  input  logic        tx_n,
  output logic        tx_p_out,
  output logic        tx_n_out,
  output logic        tx_bpv,
  output logic        tx_single
);
  logic single_d;
  assign single_d = (mode == MODE_SR_PIN) || (mode == MODE_SR_CFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_p_out  <= 1'b0;
      tx_n_out  <= 1'b0;
      tx_bpv    <= 1'b0;
      tx_single <= 1'b0;
    end else begin
      tx_p_out  <= tx_p;
      tx_n_out  <= single_d ? 1'b0 : tx_n;
      tx_bpv    <= (mode == MODE_SR_CFG) && cfg_ami && tx_n;
      tx_single <= single_d;
    end
  end

  // R7: no violation request outside configuration single rail with AMI
  a_r7_bpv_gated: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_SR_CFG || !cfg_ami) |=> !tx_bpv);

  // R6: negative rail is never driven while the encoder is enabled
  a_r6_single_quiet: assert property (@(posedge clk) disable iff (rst)
    tx_single |-> !tx_n_out);
endmodule

// File: rtl/lif_rx_path.sv
module lif_rx_path
  import lif_sysmode_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  sysif_mode_e mode,
  input  logic        clke,
  input  logic        pwr_down,
  input  logic        rec_clk,
  input  logic        rx_p,
  input  logic        rx_n,
  input  logic        dec_data,
  input  logic        dec_cv,
  output logic        rd_p,
  output logic        rd_n,
  output logic        rd_clk,
  output logic        rd_oe,
  output logic        rclk_oe
);
  logic p_d, n_d, c_d;

  always_comb begin
    unique case (mode)
      MODE_SR_PIN, MODE_SR_CFG: begin
        p_d = dec_data;
        n_d = dec_cv;
        c_d = rec_clk ^ clke;
      end
      MODE_RAW: begin
        p_d = rx_p ^ ~clke;
        n_d = rx_n ^ ~clke;
        c_d = rx_p ^ rx_n;
      end
      default: begin
        p_d = rx_p;
        n_d = rx_n;
        c_d = rec_clk ^ clke;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p    <= 1'b0;
      rd_n    <= 1'b0;
      rd_clk  <= 1'b0;
      rd_oe   <= 1'b0;
      rclk_oe <= 1'b0;
    end else begin
      rd_p    <= p_d;
      rd_n    <= n_d;
      rd_clk  <= c_d;
      rd_oe   <= ~pwr_down;
      rclk_oe <= ~pwr_down;
    end
  end

  // R10: raw clock follows the rail XOR one edge later
  a_r10_raw_clock: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RAW) |=> (rd_clk == $past(rx_p ^ rx_n)));

  // R11: power down releases both output enables
  a_r11_pd_release: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!rd_oe && !rclk_oe));
endmodule

// File: rtl/lif_sysmode.sv
module lif_sysmode
  import lif_sysmode_pkg::*;
#(
  parameter int HIGH_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_raw,
  input  logic       cfg_cr_sel,
  input  logic       cfg_sr_sel,
  input  logic       cfg_ami,
  input  logic       clke,
  input  logic       pwr_down,
  input  logic       tx_p,
  input  logic       tx_n,
  input  logic       rec_clk,
  input  logic       rx_p,
  input  logic       rx_n,
  input  logic       dec_data,
  input  logic       dec_cv,
  output logic [1:0] mode,
  output logic       tx_p_out,
  output logic       tx_n_out,
  output logic       tx_bpv,
  output logic       tx_single,
  output logic       rd_p,
  output logic       rd_n,
  output logic       rd_clk,
  output logic       rd_oe,
  output logic       rclk_oe
);
  sysif_mode_e mode_q;

  lif_mode_detect #(.HIGH_LIMIT(HIGH_LIMIT)) u_detect (
    .clk        (clk),
    .rst        (rst),
    .tx_n       (tx_n),
    .cfg_raw    (cfg_raw),
    .cfg_cr_sel (cfg_cr_sel),
    .cfg_sr_sel (cfg_sr_sel),
    .mode_q     (mode_q)
  );

  lif_tx_path u_tx (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .cfg_ami   (cfg_ami),
    .tx_p      (tx_p),
    .tx_n      (tx_n),
    .tx_p_out  (tx_p_out),
    .tx_n_out  (tx_n_out),
    .tx_bpv    (tx_bpv),
    .tx_single (tx_single)
  );

  lif_rx_path u_rx (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_q),
    .clke     (clke),
    .pwr_down (pwr_down),
    .rec_clk  (rec_clk),
    .rx_p     (rx_p),
    .rx_n     (rx_n),
    .dec_data (dec_data),
    .dec_cv   (dec_cv),
    .rd_p     (rd_p),
    .rd_n     (rd_n),
    .rd_clk   (rd_clk),
    .rd_oe    (rd_oe),
    .rclk_oe  (rclk_oe)
  );

  assign mode = mode_q;
endmodule

// File: tb/lif_sysmode_tb.sv
module lif_sysmode_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_raw = 0, cfg_cr_sel = 0, cfg_sr_sel = 0, cfg_ami = 0, clke = 0, pwr_down = 0;
  logic tx_p = 0, tx_n = 0, rec_clk = 0, rx_p = 0, rx_n = 0, dec_data = 0, dec_cv = 0;
  logic [1:0] mode;
  logic tx_p_out, tx_n_out, tx_bpv, tx_single, rd_p, rd_n, rd_clk, rd_oe, rclk_oe;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lif_sysmode u_dut (
    .clk(clk), .rst(rst), .cfg_raw(cfg_raw), .cfg_cr_sel(cfg_cr_sel),
    .cfg_sr_sel(cfg_sr_sel), .cfg_ami(cfg_ami), .clke(clke), .pwr_down(pwr_down),
    .tx_p(tx_p), .tx_n(tx_n), .rec_clk(rec_clk), .rx_p(rx_p), .rx_n(rx_n),
    .dec_data(dec_data), .dec_cv(dec_cv), .mode(mode), .tx_p_out(tx_p_out),
    .tx_n_out(tx_n_out), .tx_bpv(tx_bpv), .tx_single(tx_single), .rd_p(rd_p),
    .rd_n(rd_n), .rd_clk(rd_clk), .rd_oe(rd_oe), .rclk_oe(rclk_oe)
  );

  // inputs {raw,cr,sr,ami, clke,txp,txn,rck, rxp,rxn,dd,dcv}
  // expected {txp,txn,bpv,single,rdp,rdn,rck} then mode
  localparam logic [20:0] VEC [8] = '{
    21'b0000_0101_1001_1000101_00,
    21'b0000_1011_0110_0100010_00,
    21'b1000_0110_1011_1100011_11,
    21'b1000_1001_1100_0000110_11,
    21'b0111_0111_1001_1011011_10,
    21'b0110_1010_0010_0001101_10,
    21'b0101_0110_0111_1100010_00,
    21'b1111_1000_1011_0001111_10
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [20:0] v;
    #1;
    step();
    step();
    // R1: reset values
    chk("R1 mode", mode, 0);
    chk("R1 outputs", {tx_p_out, tx_n_out, tx_bpv, tx_single, rd_p, rd_n, rd_clk, rd_oe, rclk_oe}, 0);
    rst = 0;
    step();
    chk("R11 oe after reset", {rd_oe, rclk_oe}, 3);

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      {cfg_raw, cfg_cr_sel, cfg_sr_sel, cfg_ami, clke, tx_p, tx_n, rec_clk,
       rx_p, rx_n, dec_data, dec_cv} = v[20:9];
      step();
      step();
      chk("R4 R5 table mode", mode, int'(v[1:0]));
      chk("R6 R7 table tx", {tx_p_out, tx_n_out, tx_bpv, tx_single}, int'(v[8:5]));
      chk("R8 R9 R10 table rx", {rd_p, rd_n, rd_clk}, int'(v[4:2]));
      tx_n = 0;
      step();
    end

    // R2: 16 highs are not enough, the 17th enters mode 1
    {cfg_raw, cfg_cr_sel, cfg_sr_sel, cfg_ami, clke, tx_p} = '0;
    tx_n = 0;
    step();
    tx_n = 1;
    repeat (16) step();
    chk("R2 after 16 highs", mode, 0);
    step();
    chk("R2 after 17 highs", mode, 1);
    tx_p = 1;
    step();
    chk("R6 single tx", {tx_p_out, tx_n_out, tx_bpv, tx_single}, 4'b1001);

    // R4: configuration pair overrides pin mode; bpv with AMI
    cfg_cr_sel = 1; cfg_sr_sel = 1; cfg_ami = 1;
    step();
    chk("R4 cfg over pin", mode, 2);
    step();
    chk("R7 bpv in mode 2", tx_bpv, 1);
    cfg_ami = 0;
    step();
    chk("R7 bpv without AMI", tx_bpv, 0);
    cfg_cr_sel = 0;
    step();
    chk("R2 back to pin mode", mode, 1);

    // R3: one low sample leaves and clears the run
    tx_n = 0;
    step();
    chk("R3 low leaves", mode, 0);
    tx_n = 1;
    repeat (10) step();
    tx_n = 0;
    step();
    tx_n = 1;
    repeat (16) step();
    chk("R3 run cleared", mode, 0);
    step();
    chk("R3 full run again", mode, 1);
    tx_n = 0;
    step();

    // R10: raw rails inverted with clke low, checked while held
    cfg_raw = 1; clke = 0; rx_p = 0; rx_n = 0;
    step();
    step();
    chk("R10 raw clke low", {rd_p, rd_n, rd_clk}, 3'b110);

    // R11: power down drops both enables, release restores
    pwr_down = 1;
    step();
    chk("R11 pd enables", {rd_oe, rclk_oe}, 0);
    pwr_down = 0;
    step();
    chk("R11 release enables", {rd_oe, rclk_oe}, 3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule